// File: doc/BRIEF.md
# Selective Self-Test Span Sequencer

This block sequences a selective read-scan test of a storage medium. The host defines up to five LBA spans, each an inclusive pair of first and last block addresses. On a start request with an accepted mode code, the block reads every block of every valid span, one request at a time, over a simple request/done media port. A done pulse carries a per-block error flag. A span whose first address is greater than its last address is skipped.

When the spans are finished and the background-scan option was selected at start, the block goes on to read every block of the medium that lies outside all valid spans. Errors found in this phase are only counted and never reach the self-test result. Two retained flags cover this phase. `pending` says a background scan is unfinished. `active` says it is reading right now. Together with a retained resume address, they let the scan pick up where it stopped after a power-up, once a programmable settle time has passed.

Abort, a hardware or software reset, power-up and a new start request can all interrupt a run. Each of them leaves defined status codes behind.

Top module: `sel_selftest_seq`

## Requirements
- R1: After `rst`, `pending_o`, `active_o`, `captive_o` and `rd_req_o` are 0, `span_idx_o` is 0, and both `st_status_o` and `ol_status_o` are 00h.
- R2: `start_i` begins a test only when `mode_i` is 4 (background mode) or 132 (captive mode); any other code is ignored. While the spans are being read, `st_status_o` is F0h.
- R3: Spans are read in index order 0 to 4, each from its first to its last LBA ascending, skipping spans whose first LBA exceeds their last. When `offline_en_i` was 0 at start, the test ends after the last span with `st_status_o` = 00h, `span_idx_o` = 5 and both flags 0.
- R4: A read error during the span phase sets `st_status_o` to 70h and ends the test with no further reads and no background scan.
- R5: On entering the background phase, in the same cycle `pending_o` = 1, `active_o` = 1, `span_idx_o` = 6, `st_status_o` = 00h and `ol_status_o` = 03h.
- R6: The background phase reads LBAs 0 to `max_lba_i` ascending, skipping every LBA inside a valid span. Its read errors increment `ol_err_cnt_o` (saturating, cleared at start) and leave `st_status_o` at 00h.
- R7: When the background phase reaches `max_lba_i`, `pending_o` and `active_o` return to 0 and `ol_status_o` becomes 02h.
- R8: A `pwr_up_i` pulse while `pending_o` = 1 holds `active_o` = 0 with no reads. `active_o` rises at the (`pend_time_i`+1)-th clock edge after the one sampling the pulse. The scan then resumes at the block that was in flight.
- R9: `soft_rst_i` during the span phase sets `st_status_o` to 02h and stops reading. While `pending_o` = 1 it has no effect.
- R10: `abort_i` in the span phase sets `st_status_o` to 01h. In the background phase or the resume wait, it clears both flags and sets `ol_status_o` to 05h. In all cases reading stops.
- R11: `start_i` during a running test abandons it and starts the new test from span 0 with the current span inputs.
- R12: `captive_o` is 1 during the span phase of a test started with mode 132, and 0 otherwise.
- R13: Once raised, `rd_req_o` and `rd_lba_o` hold steady until `rd_done_i`, unless an interrupting event arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Self-test request pulse |
| mode_i | input | 8 | Test mode code (4 or 132 accepted) |
| offline_en_i | input | 1 | Run background scan after spans (sampled at start) |
| abort_i | input | 1 | Abort request pulse |
| soft_rst_i | input | 1 | Hardware/software reset event pulse |
| pwr_up_i | input | 1 | Power-up event pulse |
| pend_time_i | input | DLY_W | Settle cycles before resuming |
| max_lba_i | input | LBA_W | Last LBA of the medium |
| span_start_i | input | NUM_SPANS*LBA_W | First LBA of each span, span 0 in the low bits |
| span_end_i | input | NUM_SPANS*LBA_W | Last LBA of each span, span 0 in the low bits |
| rd_req_o | output | 1 | Block read request |
| rd_lba_o | output | LBA_W | Address of the requested block |
| rd_done_i | input | 1 | Read completion pulse |
| rd_err_i | input | 1 | Error flag qualified by rd_done_i |
| pending_o | output | 1 | Background scan unfinished |
| active_o | output | 1 | Background scan reading |
| captive_o | output | 1 | Captive span phase in progress |
| span_idx_o | output | IDX_W | Span under test (6 in background phase) |
| st_status_o | output | 8 | Self-test execution status |
| ol_status_o | output | 8 | Background collection status |
| ol_err_cnt_o | output | ERR_W | Background read errors |

## Verification
The bench builds its expected read sequence from its own span model. That model covers an inverted span, a single-block span and a span at LBA 0. A design that mishandled inclusive ends or skipping would show a missing or extra address in the read log. For power-up resume, the bench parks a background read in flight, then counts the cycles to reactivation exactly. It also checks that the parked block is read again, which catches off-by-one settle timers and resume pointers that advanced past unread blocks. Reset while pending, abort during the resume wait and restart while a read is parked are each driven separately. A design with the priority wrong would keep scanning, restart the background phase or finish the old span.

// File: rtl/sst_pkg.sv
package sst_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SPAN_NEXT,
        S_SPAN_RD,
        S_OL_NEXT,
        S_OL_RD,
        S_RESUME
    } sst_state_e;

    localparam logic [7:0] MODE_BACKGROUND = 8'd4;
    localparam logic [7:0] MODE_CAPTIVE    = 8'd132;

    localparam logic [7:0] ST_PASS        = 8'h00;
    localparam logic [7:0] ST_HOST_ABORT  = 8'h01;
    localparam logic [7:0] ST_INTERRUPTED = 8'h02;
    localparam logic [7:0] ST_READ_FAIL   = 8'h70;
    localparam logic [7:0] ST_RUNNING     = 8'hF0;

    localparam logic [7:0] OL_NONE    = 8'h00;
    localparam logic [7:0] OL_DONE    = 8'h02;
    localparam logic [7:0] OL_RUNNING = 8'h03;
    localparam logic [7:0] OL_ABORTED = 8'h05;

    function automatic logic mode_accepted(input logic [7:0] m);
        return (m == MODE_BACKGROUND) || (m == MODE_CAPTIVE);
    endfunction

    function automatic logic is_span_phase(input sst_state_e s);
        return (s == S_SPAN_NEXT) || (s == S_SPAN_RD);
    endfunction

endpackage

// File: rtl/sst_span_match.sv
module sst_span_match #(
    parameter int NUM_SPANS = 5,
    parameter int LBA_W     = 8
) (
    input  logic [NUM_SPANS*LBA_W-1:0] starts_i,
    input  logic [NUM_SPANS*LBA_W-1:0] ends_i,
    input  logic [LBA_W-1:0]           lba_i,
    output logic                       hit_o
);
    logic [NUM_SPANS-1:0] hit_vec;

    for (genvar g = 0; g < NUM_SPANS; g++) begin : g_span
        logic [LBA_W-1:0] s_lo, s_hi;
        assign s_lo = starts_i[g*LBA_W +: LBA_W];
        assign s_hi = ends_i[g*LBA_W +: LBA_W];
        assign hit_vec[g] = (s_lo <= s_hi) && (lba_i >= s_lo) && (lba_i <= s_hi);
    end

    assign hit_o = |hit_vec;
endmodule

// File: rtl/sst_resume_timer.sv
module sst_resume_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                          cnt_q <= '0;
        else if (load_i)                  cnt_q <= load_val_i;
        else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);

    // R8
    tmr_countdown_chk: assert property (@(posedge clk) disable iff (rst)
        (run_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sel_selftest_seq.sv
module sel_selftest_seq
    import sst_pkg::*;
#(
    parameter int NUM_SPANS = 5,
    parameter int LBA_W     = 8,
    parameter int DLY_W     = 16,
    parameter int ERR_W     = 8,
    localparam int IDX_W    = $clog2(NUM_SPANS + 2)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start_i,
    input  logic [7:0]                 mode_i,
    input  logic                       offline_en_i,
    input  logic                       abort_i,
    input  logic                       soft_rst_i,
    input  logic                       pwr_up_i,
    input  logic [DLY_W-1:0]           pend_time_i,
    input  logic [LBA_W-1:0]           max_lba_i,
    input  logic [NUM_SPANS*LBA_W-1:0] span_start_i,
    input  logic [NUM_SPANS*LBA_W-1:0] span_end_i,
    output logic                       rd_req_o,
    output logic [LBA_W-1:0]           rd_lba_o,
    input  logic                       rd_done_i,
    input  logic                       rd_err_i,
    output logic                       pending_o,
    output logic                       active_o,
    output logic                       captive_o,
    output logic [IDX_W-1:0]           span_idx_o,
    output logic [7:0]                 st_status_o,
    output logic [7:0]                 ol_status_o,
    output logic [ERR_W-1:0]           ol_err_cnt_o
);
    localparam logic [IDX_W-1:0] IDX_LAST    = IDX_W'(NUM_SPANS);
    localparam logic [IDX_W-1:0] IDX_OFFLINE = IDX_W'(NUM_SPANS + 1);

    sst_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [LBA_W-1:0]  cur_lba_q;
    logic [LBA_W-1:0]  res_lba_q;   // retained resume position
    logic              pending_q, active_q, ol_en_q, captive_q;
    logic [7:0]        st_q, ol_q;
    logic [ERR_W-1:0]  err_q;

    int                sel;
    logic [LBA_W-1:0]  sp_first, sp_last;
    logic              ol_hit, tmr_expired, ol_at_end;

    always_comb begin
        sel      = (int'(idx_q) < NUM_SPANS) ? int'(idx_q) : 0;
        sp_first = span_start_i[sel*LBA_W +: LBA_W];
        sp_last  = span_end_i[sel*LBA_W +: LBA_W];
    end

    assign ol_at_end = (res_lba_q == max_lba_i);

    sst_span_match #(.NUM_SPANS(NUM_SPANS), .LBA_W(LBA_W)) u_match (
        .starts_i (span_start_i),
        .ends_i   (span_end_i),
        .lba_i    (res_lba_q),
        .hit_o    (ol_hit)
    );

    sst_resume_timer #(.CNT_W(DLY_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (pwr_up_i && pending_q),
        .load_val_i (pend_time_i),
        .run_i      (state_q == S_RESUME),
        .expired_o  (tmr_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            idx_q     <= '0;
            cur_lba_q <= '0;
            res_lba_q <= '0;
            pending_q <= 1'b0;
            active_q  <= 1'b0;
            ol_en_q   <= 1'b0;
            captive_q <= 1'b0;
            st_q      <= ST_PASS;
            ol_q      <= OL_NONE;
            err_q     <= '0;
        end else if (pwr_up_i) begin
            active_q <= 1'b0;
            if (pending_q) begin
                state_q <= S_RESUME;
            end else begin
                if (is_span_phase(state_q)) st_q <= ST_INTERRUPTED;
                state_q <= S_IDLE;
            end
        end else if (start_i && mode_accepted(mode_i)) begin
            state_q   <= S_SPAN_NEXT;
            idx_q     <= '0;
            st_q      <= ST_RUNNING;
            ol_en_q   <= offline_en_i;
            captive_q <= (mode_i == MODE_CAPTIVE);
            err_q     <= '0;
            pending_q <= 1'b0;
            active_q  <= 1'b0;
            if (pending_q) ol_q <= OL_ABORTED;
        end else if (abort_i && state_q != S_IDLE) begin
            if (is_span_phase(state_q)) begin
                st_q <= ST_HOST_ABORT;
            end else begin
                pending_q <= 1'b0;
                active_q  <= 1'b0;
                ol_q      <= OL_ABORTED;
            end
            state_q <= S_IDLE;
        end else if (soft_rst_i && !pending_q && state_q != S_IDLE) begin
            st_q    <= ST_INTERRUPTED;
            state_q <= S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE: ;
                S_SPAN_NEXT: begin
                    if (idx_q == IDX_LAST) begin
                        st_q <= ST_PASS;
                        if (ol_en_q) begin
                            pending_q <= 1'b1;
                            active_q  <= 1'b1;
                            idx_q     <= IDX_OFFLINE;
                            ol_q      <= OL_RUNNING;
                            res_lba_q <= '0;
                            state_q   <= S_OL_NEXT;
                        end else begin
                            state_q <= S_IDLE;
                        end
                    end else if (sp_first > sp_last) begin
                        idx_q <= idx_q + 1'b1;
                    end else begin
                        cur_lba_q <= sp_first;
                        state_q   <= S_SPAN_RD;
                    end
                end
                S_SPAN_RD: begin
                    if (rd_done_i) begin
                        if (rd_err_i) begin
                            st_q    <= ST_READ_FAIL;
                            state_q <= S_IDLE;
                        end else if (cur_lba_q == sp_last) begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= S_SPAN_NEXT;
                        end else begin
                            cur_lba_q <= cur_lba_q + 1'b1;
                        end
                    end
                end
                S_OL_NEXT: begin
                    if (!ol_hit) begin
                        state_q <= S_OL_RD;
                    end else if (ol_at_end) begin
                        pending_q <= 1'b0;
                        active_q  <= 1'b0;
                        ol_q      <= OL_DONE;
                        state_q   <= S_IDLE;
                    end else begin
                        res_lba_q <= res_lba_q + 1'b1;
                    end
                end
                S_OL_RD: begin
                    if (rd_done_i) begin
                        if (rd_err_i && err_q != '1) err_q <= err_q + 1'b1;
                        if (ol_at_end) begin
                            pending_q <= 1'b0;
                            active_q  <= 1'b0;
                            ol_q      <= OL_DONE;
                            state_q   <= S_IDLE;
                        end else begin
                            res_lba_q <= res_lba_q + 1'b1;
                            state_q   <= S_OL_NEXT;
                        end
                    end
                end
                S_RESUME: begin
                    if (tmr_expired) begin
                        active_q <= 1'b1;
                        state_q  <= S_OL_NEXT;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign rd_req_o     = (state_q == S_SPAN_RD) || (state_q == S_OL_RD);
    assign rd_lba_o     = (state_q == S_SPAN_RD) ? cur_lba_q : res_lba_q;
    assign pending_o    = pending_q;
    assign active_o     = active_q;
    assign captive_o    = captive_q && is_span_phase(state_q);
    assign span_idx_o   = idx_q;
    assign st_status_o  = st_q;
    assign ol_status_o  = ol_q;
    assign ol_err_cnt_o = err_q;

    // R13
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && !rd_done_i && !abort_i && !start_i && !soft_rst_i && !pwr_up_i)
        |=> (rd_req_o && $stable(rd_lba_o)));

    // R5
    ol_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pending_o) |-> (active_o && st_status_o == ST_PASS
                              && ol_status_o == OL_RUNNING && span_idx_o == IDX_OFFLINE));

    // R7
    ol_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pending_o) |-> (!active_o && (ol_status_o == OL_DONE || ol_status_o == OL_ABORTED)));

    // R8
    wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (pending_o && !active_o) |-> !rd_req_o);

    // R5
    active_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
        active_o |-> pending_o);

    // R2
    span_run_chk: assert property (@(posedge clk) disable iff (rst)
        (st_status_o == ST_RUNNING) |-> !pending_o);

    // R12
    captive_chk: assert property (@(posedge clk) disable iff (rst)
        captive_o |-> (st_status_o == ST_RUNNING));
endmodule

// File: tb/sel_selftest_seq_tb.sv
module sel_selftest_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 5;
    localparam int LW = 8;
    localparam int DW = 16;
    localparam int EW = 8;
    localparam int IW = $clog2(NS + 2);

    logic clk = 0, rst = 1;
    logic start_i = 0, offline_en_i = 0, abort_i = 0, soft_rst_i = 0, pwr_up_i = 0;
    logic [7:0] mode_i = 0;
    logic [DW-1:0] pend_time_i = 0;
    logic [LW-1:0] max_lba_i = 0;
    logic [NS*LW-1:0] span_start_i = 0, span_end_i = 0;
    logic rd_req_o, rd_done_i = 0, rd_err_i = 0;
    logic [LW-1:0] rd_lba_o;
    logic pending_o, active_o, captive_o;
    logic [IW-1:0] span_idx_o;
    logic [7:0] st_status_o, ol_status_o;
    logic [EW-1:0] ol_err_cnt_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    sel_selftest_seq #(.NUM_SPANS(NS), .LBA_W(LW), .DLY_W(DW), .ERR_W(EW)) dut_i (.*);

    // media stub
    logic [255:0] bad_map = '0;
    logic hold_en = 0;
    logic [LW-1:0] hold_lba = 0;
    logic [LW-1:0] rlog [0:1023];
    int rcnt = 0;

    always @(negedge clk) begin
        if (rd_done_i) begin
            rd_done_i <= 0;
            rd_err_i  <= 0;
        end else if (rd_req_o && !(hold_en && rd_lba_o == hold_lba)) begin
            rd_done_i <= 1;
            rd_err_i  <= bad_map[rd_lba_o];
            rlog[rcnt] <= rd_lba_o;
            rcnt <= rcnt + 1;
        end
    end

    int nchk = 0, nfail = 0;
    int bs [NS];
    int be [NS];
    int exp_q [0:1023];
    int nexp;

    task automatic chk(input string req, input int act, input int expv);
        nchk++;
        if (act != expv) begin
            nfail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, expv, expv);
        end
    endtask

    task automatic set_spans(input int s0, e0, s1, e1, s2, e2, s3, e3, s4, e4);
        bs[0]=s0; be[0]=e0; bs[1]=s1; be[1]=e1; bs[2]=s2; be[2]=e2;
        bs[3]=s3; be[3]=e3; bs[4]=s4; be[4]=e4;
        for (int i = 0; i < NS; i++) begin
            span_start_i[i*LW +: LW] = LW'(bs[i]);
            span_end_i[i*LW +: LW]   = LW'(be[i]);
        end
    endtask

    function automatic bit in_model_span(input int l);
        for (int i = 0; i < NS; i++)
            if (bs[i] <= be[i] && l >= bs[i] && l <= be[i]) return 1;
        return 0;
    endfunction

    task automatic build_exp(input bit with_ol, input int maxl);
        nexp = 0;
        for (int i = 0; i < NS; i++)
            if (bs[i] <= be[i])
                for (int l = bs[i]; l <= be[i]; l++) begin exp_q[nexp] = l; nexp++; end
        if (with_ol)
            for (int l = 0; l <= maxl; l++)
                if (!in_model_span(l)) begin exp_q[nexp] = l; nexp++; end
    endtask

    task automatic cmp_log(input string req, input int base);
        chk({req, " read count"}, rcnt - base, nexp);
        for (int k = 0; k < nexp && k < rcnt - base; k++)
            chk({req, " read lba"}, int'(rlog[base + k]), exp_q[k]);
    endtask

    task automatic pulse_start(input logic [7:0] m, input logic ol);
        @(negedge clk); start_i = 1; mode_i = m; offline_en_i = ol;
        @(negedge clk); start_i = 0;
    endtask

    task automatic wait_done();
        int n = 0;
        while ((st_status_o == 8'hF0 || pending_o) && n < 5000) begin @(negedge clk); n++; end
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_pending();
        int n = 0;
        while (!pending_o && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic t_reset();
        chk("R1 pending", pending_o, 0);
        chk("R1 active", active_o, 0);
        chk("R1 captive", captive_o, 0);
        chk("R1 req", rd_req_o, 0);
        chk("R1 idx", span_idx_o, 0);
        chk("R1 st", st_status_o, 8'h00);
        chk("R1 ol", ol_status_o, 8'h00);
    endtask

    task automatic t_badmode();
        int base = rcnt;
        pulse_start(8'd5, 0);
        repeat (6) @(negedge clk);
        chk("R2 bad mode st", st_status_o, 8'h00);
        chk("R2 bad mode reads", rcnt - base, 0);
        chk("R2 bad mode req", rd_req_o, 0);
    endtask

    task automatic t_spans();
        int base = rcnt;
        set_spans(2, 4, 10, 10, 7, 6, 20, 21, 0, 0);
        pulse_start(8'd132, 0);
        chk("R2 running st", st_status_o, 8'hF0);
        chk("R12 captive", captive_o, 1);
        wait_done();
        chk("R3 st", st_status_o, 8'h00);
        chk("R3 idx", span_idx_o, 5);
        chk("R3 pending", pending_o, 0);
        chk("R3 ol", ol_status_o, 8'h00);
        chk("R12 captive after", captive_o, 0);
        build_exp(0, 0);
        cmp_log("R3", base);
    endtask

    task automatic t_err();
        int base = rcnt;
        set_spans(2, 4, 6, 6, 1, 0, 1, 0, 1, 0);
        max_lba_i = 15;
        bad_map[3] = 1;
        pulse_start(8'd4, 1);
        chk("R12 captive mode4", captive_o, 0);
        wait_done();
        chk("R4 st", st_status_o, 8'h70);
        chk("R4 pending", pending_o, 0);
        chk("R4 ol", ol_status_o, 8'h00);
        nexp = 2; exp_q[0] = 2; exp_q[1] = 3;
        cmp_log("R4", base);
        bad_map[3] = 0;
    endtask

    task automatic t_offline();
        int base = rcnt;
        set_spans(2, 4, 6, 6, 1, 0, 1, 0, 1, 0);
        max_lba_i = 15;
        bad_map[8] = 1;
        pulse_start(8'd4, 1);
        wait_pending();
        chk("R5 active", active_o, 1);
        chk("R5 idx", span_idx_o, 6);
        chk("R5 st", st_status_o, 8'h00);
        chk("R5 ol", ol_status_o, 8'h03);
        wait_done();
        chk("R7 pending", pending_o, 0);
        chk("R7 active", active_o, 0);
        chk("R7 ol", ol_status_o, 8'h02);
        chk("R6 st unaffected", st_status_o, 8'h00);
        chk("R6 err count", ol_err_cnt_o, 1);
        build_exp(1, 15);
        cmp_log("R6", base);
        bad_map[8] = 0;
    endtask

    task automatic t_power();
        int base = rcnt;
        int n;
        int T = 10;
        int quiet_bad = 0;
        set_spans(2, 4, 6, 6, 1, 0, 1, 0, 1, 0);
        max_lba_i = 15;
        pend_time_i = DW'(T);
        hold_en = 1; hold_lba = 5;
        pulse_start(8'd4, 1);
        n = 0;
        while (!(rd_req_o && rd_lba_o == 5 && pending_o) && n < 2000) begin @(negedge clk); n++; end
        @(negedge clk); pwr_up_i = 1;
        @(negedge clk); pwr_up_i = 0;
        n = 1;
        while (!active_o && n < 200) begin
            if (rd_req_o || !pending_o) quiet_bad++;
            @(negedge clk); n++;
        end
        chk("R8 quiet wait", quiet_bad, 0);
        chk("R8 resume delay", n, T + 2);
        hold_en = 0;
        wait_done();
        chk("R8 ol", ol_status_o, 8'h02);
        build_exp(1, 15);
        cmp_log("R8", base);
    endtask

    task automatic t_srst();
        set_spans(2, 4, 6, 6, 1, 0, 1, 0, 1, 0);
        max_lba_i = 15;
        pulse_start(8'd4, 1);
        wait_pending();
        @(negedge clk); soft_rst_i = 1;
        @(negedge clk); soft_rst_i = 0;
        @(negedge clk);
        chk("R9 pending kept", pending_o, 1);
        chk("R9 active kept", active_o, 1);
        chk("R9 ol kept", ol_status_o, 8'h03);
        wait_done();
        chk("R9 ol completes", ol_status_o, 8'h02);
        pulse_start(8'd4, 1);
        chk("R9 running", st_status_o, 8'hF0);
        soft_rst_i = 1;
        @(negedge clk); soft_rst_i = 0;
        chk("R9 span st", st_status_o, 8'h02);
        chk("R9 span req", rd_req_o, 0);
        repeat (4) @(negedge clk);
        chk("R9 span pending", pending_o, 0);
    endtask

    task automatic t_abort();
        int n;
        int req_seen = 0;
        set_spans(2, 4, 6, 6, 1, 0, 1, 0, 1, 0);
        max_lba_i = 15;
        pulse_start(8'd4, 1);
        abort_i = 1;
        @(negedge clk); abort_i = 0;
        chk("R10 span st", st_status_o, 8'h01);
        chk("R10 span req", rd_req_o, 0);
        pulse_start(8'd4, 1);
        wait_pending();
        @(negedge clk); abort_i = 1;
        @(negedge clk); abort_i = 0;
        chk("R10 ol pending", pending_o, 0);
        chk("R10 ol active", active_o, 0);
        chk("R10 ol status", ol_status_o, 8'h05);
        chk("R10 ol st", st_status_o, 8'h00);
        pend_time_i = 4;
        hold_en = 1; hold_lba = 5;
        pulse_start(8'd4, 1);
        n = 0;
        while (!(rd_req_o && rd_lba_o == 5) && n < 2000) begin @(negedge clk); n++; end
        pwr_up_i = 1;
        @(negedge clk); pwr_up_i = 0;
        @(negedge clk); abort_i = 1;
        @(negedge clk); abort_i = 0;
        hold_en = 0;
        for (int k = 0; k < 20; k++) begin
            if (rd_req_o) req_seen++;
            @(negedge clk);
        end
        chk("R10 wait no reads", req_seen, 0);
        chk("R10 wait pending", pending_o, 0);
        chk("R10 wait ol", ol_status_o, 8'h05);
    endtask

    task automatic t_restart();
        int base = rcnt;
        int n = 0;
        set_spans(2, 4, 1, 0, 1, 0, 1, 0, 1, 0);
        hold_en = 1; hold_lba = 3;
        pulse_start(8'd132, 0);
        while (!(rd_req_o && rd_lba_o == 3) && n < 2000) begin @(negedge clk); n++; end
        set_spans(9, 9, 1, 0, 1, 0, 1, 0, 1, 0);
        pulse_start(8'd4, 0);
        chk("R11 restarted st", st_status_o, 8'hF0);
        chk("R11 captive new mode", captive_o, 0);
        hold_en = 0;
        wait_done();
        chk("R11 st", st_status_o, 8'h00);
        nexp = 2; exp_q[0] = 2; exp_q[1] = 9;
        cmp_log("R11", base);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_badmode();
        t_spans();
        t_err();
        t_offline();
        t_power();
        t_srst();
        t_abort();
        t_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule